// File: doc/BRIEF.md
# Self-Synchronizing Serial Scrambler and Descrambler

This block whitens a clocked serial data stream on its way to the line and restores the original stream on the far side. The transmit half runs each data bit through a 15-stage feedback shift register. Every new first-stage bit is the data bit XORed with the contents of stage 7 and stage 15. The line bit is read from the last stage. The receive half keeps the most recent received line bits in a shift register of its own and cancels the same two taps. Because it runs only on what it receives, it locks to the far-end scrambler after fifteen line bits, and no seed has to be exchanged.

An inhibit input switches both halves to plain pass-through. The transmit register then becomes a delay line, so the line timing stays the same in both modes. An indicator output follows the inhibit input. Two idle monitors each count clocks without a level change, one on the transmit data input and one on the received line input, and raise an alarm when the count reaches a parameter limit.

Top module: `scr_link_randomizer`

## Requirements
- R1: An active-low reset clears the transmit register, the receive register and the recovered-data output, the inhibit indicator and both idle alarms, at once and without waiting for a clock.
- R2: The transmit register advances one stage on every rising clock edge. `tx_line_out` shows the last stage. A value loaded into the first stage at one edge appears on `tx_line_out` after the 14th edge that follows.
- R3: While not inhibited, the value loaded into the first stage is `tx_data_in` XOR stage 7 XOR stage 15, where stage 1 is the most recently loaded bit.
- R4: While not inhibited, `rx_data_out` is registered. After each edge it equals the line bit sampled at that edge XOR the line bits sampled 7 and 15 edges earlier.
- R5: With `tx_line_out` looped to `rx_line_in` and at least 15 line bits received in the current mode, `rx_data_out` after an edge equals the `tx_data_in` bit sampled 15 edges earlier.
- R6: From reset, an all-zero `tx_data_in` keeps `tx_line_out` at zero.
- R7: In loopback, one inverted line bit corrupts exactly three recovered bits: the bits shown after the edge that samples it and after the 7th and 15th edges that follow. All other recovered bits stay correct.
- R8: While `inhibit` is high, the first stage loads `tx_data_in` unchanged, so the transmit latency matches R2. `rx_data_out` then shows the line bit sampled at the same edge.
- R9: `inhibit_ind` shows the `inhibit` value sampled at the previous rising edge.
- R10: An idle alarm rises after the 64th consecutive edge (default limit) at which its stream holds its level. It stays high while the level holds, and falls after the first edge that samples a change.
- R11: The transmit alarm watches only `tx_data_in` and the receive alarm watches only `rx_line_in`. Activity on one stream does not clear or raise the other alarm.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared bit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| inhibit | input | 1 | High selects pass-through in both directions |
| tx_data_in | input | 1 | Transmit data bit |
| tx_line_out | output | 1 | Scrambled line bit (last register stage) |
| rx_line_in | input | 1 | Received line bit from the far end |
| rx_data_out | output | 1 | Recovered data bit |
| inhibit_ind | output | 1 | Pass-through indicator |
| tx_idle_alarm | output | 1 | No level change seen on the transmit data input |
| rx_idle_alarm | output | 1 | No level change seen on the received line |

## Verification
The transmit path is driven with constant words, alternating words, single-one words and mixed words. Constant words show whether both feedback taps enter the next-state equation. Alternating and mixed words expose a tap at the wrong stage. Zero data from reset shows the lock-up state, and zero data following a busy stretch shows that the register state alone keeps the line moving. Loopback runs check end-to-end recovery in scrambled mode and in pass-through mode, and an open-loop random line pattern checks the descrambler tap positions directly. A single inverted line bit confirms that exactly three recovered bits go wrong, at the expected offsets. Held and toggling streams separate the two idle alarms and check the exact edge at which each alarm rises.

// File: rtl/scr_pkg.sv
`timescale 1ns/1ps
package scr_pkg;

  // Datapath mode shared by both halves of the randomizer.
  typedef enum logic {
    SCR_MODE_MIX  = 1'b0,
    SCR_MODE_PASS = 1'b1
  } scr_mode_e;

  // Feedback combine used on both sides: in mix mode the bit is folded
  // with two register taps, in pass mode it goes through untouched.
  function automatic logic scr_fold(input scr_mode_e mode,
                                    input logic      bit_in,
                                    input logic      tap_mid,
                                    input logic      tap_end);
    logic res;
    if (mode == SCR_MODE_PASS) res = bit_in;
    else                       res = bit_in ^ tap_mid ^ tap_end;
    return res;
  endfunction

endpackage

// File: rtl/scr_rst_sync.sv
`timescale 1ns/1ps
module scr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  localparam int unsigned TOP = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  // The reset asserts at once and is released through a short flop chain.
  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[TOP];

endmodule

// File: rtl/scr_whitener.sv
`timescale 1ns/1ps
module scr_whitener
  import scr_pkg::*;
#(
  parameter int unsigned LEN = 15,
  parameter int unsigned TAP = 7
) (
  input  logic      clk,
  input  logic      rst_n,
  input  scr_mode_e mode,
  input  logic      din,
  output logic      line_out
);
  localparam int unsigned LAST = LEN - 1;
  localparam int unsigned MID  = TAP - 1;

  // Bit 0 is stage 1 (newest), bit LAST is the final stage.
  logic [LEN-1:0] sr_q;
  logic [LEN-1:0] sr_d;
  logic           head_d;

  always_comb begin
    head_d = scr_fold(mode, din, sr_q[MID], sr_q[LAST]);
    sr_d   = {sr_q[LEN-2:0], head_d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign line_out = sr_q[LAST];

  // R2
  wh_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> sr_q[LEN-1:1] == $past(sr_q[LEN-2:0]));

  // R3
  wh_feed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SCR_MODE_MIX) |=> sr_q[0] == ($past(din) ^ $past(sr_q[MID]) ^ $past(line_out)));

  // R8
  wh_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SCR_MODE_PASS) |=> sr_q[0] == $past(din));

  // R6
  wh_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_q == '0 && din == 1'b0) |=> line_out == 1'b0);

endmodule

// File: rtl/scr_dewhitener.sv
`timescale 1ns/1ps
module scr_dewhitener
  import scr_pkg::*;
#(
  parameter int unsigned LEN = 15,
  parameter int unsigned TAP = 7
) (
  input  logic      clk,
  input  logic      rst_n,
  input  scr_mode_e mode,
  input  logic      line_in,
  output logic      dout
);
  localparam int unsigned LAST = LEN - 1;
  localparam int unsigned MID  = TAP - 1;

  // History of received line bits; bit 0 is the bit taken one edge ago.
  logic [LEN-1:0] hist_q;
  logic [LEN-1:0] hist_d;
  logic           dout_q;
  logic           dout_d;

  always_comb begin
    hist_d = {hist_q[LEN-2:0], line_in};
    dout_d = scr_fold(mode, line_in, hist_q[MID], hist_q[LAST]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      dout_q <= 1'b0;
    end else begin
      hist_q <= hist_d;
      dout_q <= dout_d;
    end
  end

  assign dout = dout_q;

  // R4
  dw_hist_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> hist_q[0] == $past(line_in));

  // R8
  dw_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SCR_MODE_PASS) |=> dout == $past(line_in));

endmodule

// File: rtl/scr_idle_mon.sv
`timescale 1ns/1ps
module scr_idle_mon #(
  parameter int unsigned LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic alarm
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic          prev_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          alarm_q;
  logic          alarm_d;
  logic          edge_seen;
  logic          cnt_en;

  always_comb begin
    edge_seen = (din != prev_q);
    cnt_en    = !edge_seen && (cnt_q != LIM);
    if (edge_seen)   cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + 1'b1;
    else             cnt_d = cnt_q;
    alarm_d = (cnt_d == LIM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      cnt_q   <= '0;
      alarm_q <= 1'b0;
    end else begin
      prev_q  <= din;
      cnt_q   <= cnt_d;
      alarm_q <= alarm_d;
    end
  end

  assign alarm = alarm_q;

  // R10
  im_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (din != prev_q) |=> !alarm);

  // R10
  im_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm && din == prev_q) |=> alarm);

  // R10
  im_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM);

endmodule

// File: rtl/scr_link_randomizer.sv
`timescale 1ns/1ps
module scr_link_randomizer
  import scr_pkg::*;
#(
  parameter int unsigned LEN        = 15,
  parameter int unsigned TAP        = 7,
  parameter int unsigned IDLE_LIMIT = 64,
  parameter int unsigned SYNC_STG   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inhibit,
  input  logic tx_data_in,
  output logic tx_line_out,
  input  logic rx_line_in,
  output logic rx_data_out,
  output logic inhibit_ind,
  output logic tx_idle_alarm,
  output logic rx_idle_alarm
);
  localparam int unsigned NMON = 2;

  logic            rst_n_int;
  scr_mode_e       mode;
  logic            ind_q;
  logic            ind_d;
  logic [NMON-1:0] mon_din;
  logic [NMON-1:0] mon_alarm;

  scr_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk       (clk),
    .arst_n    (rst_n),
    .rst_n_sync(rst_n_int)
  );

  assign mode = inhibit ? SCR_MODE_PASS : SCR_MODE_MIX;

  scr_whitener #(.LEN(LEN), .TAP(TAP)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .mode    (mode),
    .din     (tx_data_in),
    .line_out(tx_line_out)
  );

  scr_dewhitener #(.LEN(LEN), .TAP(TAP)) u_rx (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .mode   (mode),
    .line_in(rx_line_in),
    .dout   (rx_data_out)
  );

  // One idle monitor per direction: index 0 transmit data, index 1 received line.
  assign mon_din = {rx_line_in, tx_data_in};

  for (genvar g = 0; g < NMON; g++) begin : g_mon
    scr_idle_mon #(.LIMIT(IDLE_LIMIT)) u_mon (
      .clk  (clk),
      .rst_n(rst_n_int),
      .din  (mon_din[g]),
      .alarm(mon_alarm[g])
    );
  end

  assign tx_idle_alarm = mon_alarm[0];
  assign rx_idle_alarm = mon_alarm[1];

  always_comb begin
    ind_d = inhibit;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) ind_q <= 1'b0;
    else            ind_q <= ind_d;
  end

  assign inhibit_ind = ind_q;

  // R9
  ind_follow_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    1'b1 |=> inhibit_ind == $past(inhibit));

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    !rst_n_int |-> (!tx_line_out && !rx_data_out && !inhibit_ind && !tx_idle_alarm && !rx_idle_alarm));

endmodule

// File: tb/scr_link_randomizer_bench.sv
`timescale 1ns/1ps
module scr_link_randomizer_bench;

  logic clk = 1'b0;
  logic rst_n;
  logic inhibit;
  logic tx_data_in;
  logic tx_line_out;
  logic rx_line_in;
  logic rx_data_out;
  logic inhibit_ind;
  logic tx_idle_alarm;
  logic rx_idle_alarm;

  logic loop_en;
  logic rx_drv;
  logic flip;

  always #10 clk = ~clk;

  assign rx_line_in = loop_en ? (tx_line_out ^ flip) : rx_drv;

  scr_link_randomizer u_scr_link_randomizer (
    .clk          (clk),
    .rst_n        (rst_n),
    .inhibit      (inhibit),
    .tx_data_in   (tx_data_in),
    .tx_line_out  (tx_line_out),
    .rx_line_in   (rx_line_in),
    .rx_data_out  (rx_data_out),
    .inhibit_ind  (inhibit_ind),
    .tx_idle_alarm(tx_idle_alarm),
    .rx_idle_alarm(rx_idle_alarm)
  );

  // Bit 16 selects pass-through; bits 15:0 are sent MSB first.
  localparam logic [16:0] VECS [0:11] = '{
    17'h0_FFFF, 17'h0_0000, 17'h0_AAAA, 17'h0_5555,
    17'h0_8001, 17'h0_1234, 17'h1_F0F0, 17'h1_0FF0,
    17'h1_C3A5, 17'h0_0000, 17'h0_7E81, 17'h0_DEAD
  };

  int   vec_cnt  = 0;
  int   miss_cnt = 0;
  int   n        = 0;
  int   last_chg = -100;
  logic cur_byp  = 1'b0;
  logic [14:0] mdl = '0;
  logic dh [0:4095];
  logic rh [0:4095];

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, miss_cnt);
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    vec_cnt++;
    if (act !== exp) begin
      miss_cnt++;
      $display("FAIL %s: got %b expected %b (step %0d)", tag, act, exp, n - 1);
    end
  endtask

  // One clock: drive at the falling edge, let the rising edge act, sample at
  // the next falling edge. The transmit model follows R2, R3 and R8.
  task automatic step(input logic d, input logic byp, input logic r, input logic flp);
    if (byp !== cur_byp) last_chg = n;
    cur_byp    = byp;
    tx_data_in = d;
    inhibit    = byp;
    rx_drv     = r;
    flip       = flp;
    #1;
    dh[n] = d;
    rh[n] = rx_line_in;
    @(negedge clk);
    mdl = {mdl[13:0], byp ? d : (d ^ mdl[6] ^ mdl[14])};
    n++;
    if (byp) chk(tx_line_out, mdl[14], "R8 tx pass-through");
    else     chk(tx_line_out, mdl[14], "R2 R3 tx line");
    chk(inhibit_ind, byp, "R9 indicator");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miss_cnt++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    report();
    $finish;
  end

  initial begin
    rst_n      = 1'b0;
    inhibit    = 1'b1;
    tx_data_in = 1'b1;
    rx_drv     = 1'b1;
    flip       = 1'b0;
    loop_en    = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs cleared while reset is held, despite active inputs
    chk(tx_line_out,   1'b0, "R1 tx line in reset");
    chk(rx_data_out,   1'b0, "R1 rx data in reset");
    chk(inhibit_ind,   1'b0, "R1 indicator in reset");
    chk(tx_idle_alarm, 1'b0, "R1 tx alarm in reset");
    chk(rx_idle_alarm, 1'b0, "R1 rx alarm in reset");
    inhibit    = 1'b0;
    tx_data_in = 1'b0;
    loop_en    = 1'b1;
    rst_n      = 1'b1;

    // R6: all-zero data from reset leaves the line at zero
    for (int i = 0; i < 40; i++) begin
      step(1'b0, 1'b0, 1'b0, 1'b0);
      chk(tx_line_out, 1'b0, "R6 lock-up line");
      chk(rx_data_out, 1'b0, "R6 lock-up recovered");
    end

    // Vector table in loopback: R2 R3 on the line, R5 and R8 on recovery
    for (int v = 0; v < 12; v++) begin
      for (int b = 15; b >= 0; b--) begin
        step(VECS[v][b], VECS[v][16], 1'b0, 1'b0);
        if ((n - 1) - last_chg >= 32)
          chk(rx_data_out, dh[n - 1 - 15], VECS[v][16] ? "R8 loop pass-through" : "R5 loop recovery");
      end
    end

    // R4: open loop, random line bits, descrambler tap check
    loop_en = 1'b0;
    for (int i = 0; i < 60; i++) begin
      step(1'($urandom), 1'b0, 1'($urandom), 1'b0);
      chk(rx_data_out, rh[n-1] ^ rh[n-1-7] ^ rh[n-1-15], "R4 descramble taps");
    end
    // R8: open loop pass-through, recovered bit is the line bit just sampled
    for (int i = 0; i < 30; i++) begin
      step(1'($urandom), 1'b1, 1'($urandom), 1'b0);
      chk(rx_data_out, rh[n-1], "R8 rx pass-through");
    end

    // R7: one inverted line bit in loopback
    loop_en  = 1'b1;
    last_chg = n;
    for (int i = 0; i < 40; i++) begin
      step(1'($urandom), 1'b0, 1'b0, 1'b0);
      if ((n - 1) - last_chg >= 32) chk(rx_data_out, dh[n - 1 - 15], "R5 resync");
    end
    for (int k = 0; k < 22; k++) begin
      step(1'($urandom), 1'b0, 1'b0, (k == 0) ? 1'b1 : 1'b0);
      chk(rx_data_out, dh[n - 1 - 15] ^ ((k == 0 || k == 7 || k == 15) ? 1'b1 : 1'b0),
          "R7 error spread");
    end

    // R10 R11: transmit stream held, received line toggling
    loop_en = 1'b0;
    step(1'b0, 1'b0, 1'b1, 1'b0);
    for (int j = 0; j < 70; j++) begin
      step(1'b1, 1'b0, j[0], 1'b0);
      chk(tx_idle_alarm, (j >= 64) ? 1'b1 : 1'b0, "R10 tx alarm timing");
      chk(rx_idle_alarm, 1'b0, "R11 rx alarm unaffected");
    end
    step(1'b0, 1'b0, 1'b0, 1'b0);
    chk(tx_idle_alarm, 1'b0, "R10 tx alarm clears");
    // received line held, transmit stream toggling
    for (int j = 0; j < 70; j++) begin
      step(~j[0], 1'b0, 1'b1, 1'b0);
      chk(rx_idle_alarm, (j >= 64) ? 1'b1 : 1'b0, "R10 rx alarm timing");
      chk(tx_idle_alarm, 1'b0, "R11 tx alarm unaffected");
    end
    step(1'b0, 1'b0, 1'b0, 1'b0);
    chk(rx_idle_alarm, 1'b0, "R10 rx alarm clears");

    // R1: asynchronous clear in mid-traffic
    loop_en = 1'b1;
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 1'b0, 1'b0);
    #5;
    rst_n = 1'b0;
    #1;
    chk(tx_line_out,   1'b0, "R1 async clear line");
    chk(rx_data_out,   1'b0, "R1 async clear recovered");
    chk(inhibit_ind,   1'b0, "R1 async clear indicator");

    report();
    $finish;
  end

endmodule